// File: doc/BRIEF.md
# Request-Paced Byte DMA Channel

This block is one DMA channel that copies bytes from a source address to a destination address, one byte per bus transaction pair: a read of the source, then a write of the byte just read to the destination. It is meant to sit between a serial controller's receive and transmit FIFOs and memory. For example, a receive channel drains the receive-FIFO register at register address 0xF4 into a buffer, and a transmit channel feeds a buffer into the transmit-FIFO register at 0x85. The peripheral paces the channel through a request input.

Software programs four registers through a simple write/read port: a control register, a source address, a destination address and a 16-bit byte count. It then sets the GO bit. The channel counts the count down once per byte moved. When the count reaches zero it raises Done, drops GO, and ignores any further requests until it is programmed again. Each address can point at register space, where only its low byte reaches the bus, or at data memory. Each address can also advance after every byte or stay fixed.

Top module: `dma_demand_chan`

## Requirements
- R1: After reset, all four registers read as zero, GO (control bit 0) and Done (control bit 1) are clear, and `bus_req` is low.
- R2: No transfer starts while GO is clear. Requests that arrive while GO is clear are discarded and are not remembered once GO is set.
- R3: With control bit 2 = 0 and bit 3 = 1 (demand mode), each request moves exactly one byte. A request that arrives while an earlier byte is still in flight is kept pending and is served afterwards.
- R4: With control bit 2 = 0 and bit 3 = 0 (burst mode), no byte moves before the first request. One request then moves the whole remaining count.
- R5: With control bit 2 = 1 (free-running), bytes move back to back without any request until the count is exhausted.
- R6: Every byte is one read from the source (`bus_we` = 0) followed by one write of the returned byte to the destination (`bus_we` = 1). The request, direction and address stay unchanged until `bus_ack`.
- R7: Control bit 4 set makes the source address increase by one after each byte, and bit 6 does the same for the destination. When the bit is clear, that address stays unchanged.
- R8: Control bit 5 set puts the source in register space, and bit 7 does the same for the destination. In register space, `bus_space` = 1 and the bus address carries only the low 8 address bits, with the high byte driven as zero.
- R9: The byte count (register index 3) decreases by one per completed write. It can be read back live, at its current value, in the middle of a run.
- R10: When GO is set and the count is zero, Done sets and GO clears. This happens after the last byte, and also at once if GO is set with a zero count. After that no bus transaction occurs, even if requests arrive.
- R11: Writing the control register with bit 0 = 1 clears Done and restarts the channel with the newly loaded count.

Register indices on `reg_addr`: 0 control (bits 7:2 configuration, bit 1 Done read-only, bit 0 GO), 1 source address, 2 destination address, 3 byte count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| periph_req | input | 1 | Peripheral request, one per cycle high |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_space | output | 1 | 1 = register space, 0 = data memory |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Byte to write |
| bus_ack | input | 1 | Transaction complete |
| bus_rdata | input | 8 | Byte read, valid with `bus_ack` |
| done | output | 1 | Done flag |

## Verification
The assertions watch the following on every cycle:
- the bus handshake: a request and its address stay held until acknowledged, a transaction always opens with a read, and a write follows only a completed read;
- the zeroed high address byte in register space;
- the one-step decrement of the count on each write;
- the absence of bus activity while Done is set or the count is zero.

The bench scenarios show what needs a whole sequence:
- the pacing rules of the demand, burst and free-running modes;
- the pending of requests that arrive during a transfer;
- the discarding of requests made before GO;
- the increment and fixed address rules against a scoreboard of expected writes;
- the restart after Done.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam logic [1:0] RA_CTL = 2'd0;
  localparam logic [1:0] RA_SRC = 2'd1;
  localparam logic [1:0] RA_DST = 2'd2;
  localparam logic [1:0] RA_CNT = 2'd3;

  // Configuration field order matches control bits 7 down to 2.
  typedef struct packed {
    logic dst_reg;
    logic dst_inc;
    logic src_reg;
    logic src_inc;
    logic demand;
    logic free_run;
  } chan_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } eng_state_t;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  input  logic         xfer_done,
  input  logic         busy,
  output chan_cfg_t    cfg,
  output logic [W-1:0] src_addr,
  output logic [W-1:0] dst_addr,
  output logic [W-1:0] cnt,
  output logic         go,
  output logic         done,
  output logic [W-1:0] reg_rdata
);

  chan_cfg_t    cfg_q, cfg_d;
  logic [W-1:0] src_q, src_d, dst_q, dst_d, cnt_q, cnt_d;
  logic         go_q, go_d, done_q, done_d;
  logic         ctl_wr, ctl_en, src_en, dst_en, cnt_en, flag_en;

  assign ctl_wr = reg_we && (reg_addr == RA_CTL);

  always_comb begin
    cfg_d  = cfg_q;
    src_d  = src_q;
    dst_d  = dst_q;
    cnt_d  = cnt_q;
    go_d   = go_q;
    done_d = done_q;
    ctl_en = 1'b0;
    src_en = 1'b0;
    dst_en = 1'b0;
    cnt_en = 1'b0;
    flag_en = 1'b0;
    if (reg_we) begin
      unique case (reg_addr)
        RA_CTL: begin
          cfg_d   = chan_cfg_t'(reg_wdata[7:2]);
          go_d    = reg_wdata[0];
          ctl_en  = 1'b1;
          flag_en = 1'b1;
          if (reg_wdata[0]) done_d = 1'b0;
        end
        RA_SRC: begin src_d = reg_wdata; src_en = 1'b1; end
        RA_DST: begin dst_d = reg_wdata; dst_en = 1'b1; end
        default: begin cnt_d = reg_wdata; cnt_en = 1'b1; end
      endcase
    end
    // A completed byte takes priority over a software load.
    if (xfer_done) begin
      src_d  = src_q + {{(W-1){1'b0}}, cfg_q.src_inc};
      dst_d  = dst_q + {{(W-1){1'b0}}, cfg_q.dst_inc};
      cnt_d  = cnt_q - {{(W-1){1'b0}}, 1'b1};
      src_en = 1'b1;
      dst_en = 1'b1;
      cnt_en = 1'b1;
    end
    if (!ctl_wr && go_q && (cnt_q == '0) && !busy) begin
      go_d    = 1'b0;
      done_d  = 1'b1;
      flag_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      go_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (ctl_en)  cfg_q  <= cfg_d;
      if (src_en)  src_q  <= src_d;
      if (dst_en)  dst_q  <= dst_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (flag_en) begin
        go_q   <= go_d;
        done_q <= done_d;
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_CTL:  reg_rdata = {{(W-8){1'b0}}, cfg_q, done_q, go_q};
      RA_SRC:  reg_rdata = src_q;
      RA_DST:  reg_rdata = dst_q;
      default: reg_rdata = cnt_q;
    endcase
  end

  assign cfg      = cfg_q;
  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign cnt      = cnt_q;
  assign go       = go_q;
  assign done     = done_q;

endmodule

// File: rtl/dma_chan_reqtrack.sv
module dma_chan_reqtrack #(
  parameter int PEND_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  input  logic accept,
  input  logic consume,
  input  logic clear,
  output logic pend_any
);

  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [PEND_W-1:0] pend_q, pend_d;
  logic              inc, dec, pend_en;

  assign inc = req_in && accept && (pend_q != PEND_MAX);
  assign dec = consume && (pend_q != '0);

  always_comb begin
    pend_d  = pend_q;
    pend_en = 1'b0;
    if (clear) begin
      pend_d  = '0;
      pend_en = 1'b1;
    end else if (inc != dec) begin
      pend_d  = inc ? pend_q + 1'b1 : pend_q - 1'b1;
      pend_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_any = (pend_q != '0);

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int W      = 16,
  parameter int DW     = 8,
  parameter int RSP_AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          cnt_zero,
  input  logic          free_run,
  input  logic          demand,
  input  logic          src_reg,
  input  logic          dst_reg,
  input  logic          pend_any,
  input  logic [W-1:0]  src_addr,
  input  logic [W-1:0]  dst_addr,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_space,
  output logic [W-1:0]  bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          xfer_done,
  output logic          consume,
  output logic          busy
);

  localparam int HI_W = W - RSP_AW;

  eng_state_t    st_q, st_d;
  logic [DW-1:0] byte_q, byte_d;
  logic          byte_en, start;

  assign start = go && !cnt_zero && (free_run || pend_any);

  always_comb begin
    st_d      = st_q;
    byte_d    = byte_q;
    byte_en   = 1'b0;
    xfer_done = 1'b0;
    consume   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d    = ST_RD;
        consume = !free_run && demand;
      end
      ST_RD: if (bus_ack) begin
        st_d    = ST_WR;
        byte_d  = bus_rdata;
        byte_en = 1'b1;
      end
      default: if (bus_ack) begin
        st_d      = ST_IDLE;
        xfer_done = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      byte_q <= '0;
    end else begin
      st_q <= st_d;
      if (byte_en) byte_q <= byte_d;
    end
  end

  always_comb begin
    bus_req   = (st_q != ST_IDLE);
    bus_we    = (st_q == ST_WR);
    bus_space = bus_we ? dst_reg : src_reg;
    if (bus_we)
      bus_addr = dst_reg ? {{HI_W{1'b0}}, dst_addr[RSP_AW-1:0]} : dst_addr;
    else
      bus_addr = src_reg ? {{HI_W{1'b0}}, src_addr[RSP_AW-1:0]} : src_addr;
  end

  assign bus_wdata = byte_q;
  assign busy      = (st_q != ST_IDLE);

endmodule

// File: rtl/dma_demand_chan.sv
module dma_demand_chan
  import dma_chan_pkg::*;
#(
  parameter int W      = 16,
  parameter int DW     = 8,
  parameter int RSP_AW = 8,
  parameter int PEND_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic          periph_req,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_space,
  output logic [W-1:0]  bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          done
);

  chan_cfg_t    cfg;
  logic [W-1:0] src_q, dst_q, cnt_q;
  logic         go_q, xfer_done, busy, consume, pend_any;

  dma_chan_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .xfer_done (xfer_done),
    .busy      (busy),
    .cfg       (cfg),
    .src_addr  (src_q),
    .dst_addr  (dst_q),
    .cnt       (cnt_q),
    .go        (go_q),
    .done      (done),
    .reg_rdata (reg_rdata)
  );

  dma_chan_reqtrack #(.PEND_W(PEND_W)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_in   (periph_req),
    .accept   (go_q && !cfg.free_run),
    .consume  (consume),
    .clear    (!go_q),
    .pend_any (pend_any)
  );

  dma_chan_engine #(.W(W), .DW(DW), .RSP_AW(RSP_AW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go_q),
    .cnt_zero  (cnt_q == '0),
    .free_run  (cfg.free_run),
    .demand    (cfg.demand),
    .src_reg   (cfg.src_reg),
    .dst_reg   (cfg.dst_reg),
    .pend_any  (pend_any),
    .src_addr  (src_q),
    .dst_addr  (dst_q),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_space (bus_space),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .xfer_done (xfer_done),
    .consume   (consume),
    .busy      (busy)
  );

endmodule

// File: rtl/dma_demand_chan_chk.sv
module dma_demand_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_we,
  input logic         bus_req,
  input logic         bus_we,
  input logic         bus_space,
  input logic [W-1:0] bus_addr,
  input logic         bus_ack,
  input logic         done,
  input logic [W-1:0] cnt
);

  assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)));

  assert_read_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !bus_we);

  assert_write_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we) |-> $past(bus_ack));

  assert_reg_space_high_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_space) |-> (bus_addr[W-1:8] == '0));

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_ack && !reg_we) |=> (cnt == $past(cnt) - 1'b1));

  assert_quiet_when_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);

  assert_no_start_at_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> (cnt != '0));

endmodule

bind dma_demand_chan dma_demand_chan_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_space (bus_space),
  .bus_addr  (bus_addr),
  .bus_ack   (bus_ack),
  .done      (done),
  .cnt       (cnt_q)
);

// File: tb/dma_demand_chan_test.sv
`timescale 1ns/100ps
module dma_demand_chan_test;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        periph_req;
  logic        bus_req, bus_we, bus_space;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_ack;
  logic [7:0]  bus_rdata;
  logic        done;

  int checks = 0;
  int failures = 0;
  int txns = 0;
  logic [7:0]  rx_seq;
  logic [7:0]  exp_rx;
  logic [24:0] exp_q[$];

  dma_demand_chan uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .bus_req(bus_req), .bus_we(bus_we), .bus_space(bus_space),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ 8'h5A ^ a[15:8];
  endfunction

  // Bus responder and scoreboard monitor, acting between clock edges.
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack   = 1'b0;
      bus_rdata = 8'h00;
      rx_seq    = 8'h30;
    end else if (bus_req && !bus_ack) begin
      bus_ack = 1'b1;
      txns++;
      if (!bus_we) begin
        if (bus_space) begin
          if (bus_addr[7:0] == 8'hF4) begin
            bus_rdata = rx_seq;
            rx_seq    = rx_seq + 8'd1;
          end else begin
            bus_rdata = 8'hEE;
          end
        end else begin
          bus_rdata = pat(bus_addr);
        end
      end else begin
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R6 unexpected write act=%h exp=none", {bus_space, bus_addr, bus_wdata});
        end else begin
          logic [24:0] e;
          e = exp_q.pop_front();
          if ({bus_space, bus_addr, bus_wdata} !== e) begin
            failures++;
            $display("FAIL R6 bus write act=%h exp=%h", {bus_space, bus_addr, bus_wdata}, e);
          end
        end
      end
    end else begin
      bus_ack = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); periph_req = 1'b1;
    @(negedge clk); periph_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done(input string tag);
    int k;
    k = 0;
    while (!done && k < 2000) begin @(negedge clk); k++; end
    chk(tag, {31'd0, done}, 32'd1);
    idle(2);
  endtask

  task automatic push(input logic sp, input logic [15:0] a, input logic [7:0] d);
    exp_q.push_back({sp, a, d});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int t0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 16'd0; periph_req = 1'b0;
    exp_rx = 8'h30;
    idle(4);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd(2'd0, v); chk("R1 ctl", v, 16'h0000);
    rd(2'd1, v); chk("R1 src", v, 16'h0000);
    rd(2'd2, v); chk("R1 dst", v, 16'h0000);
    rd(2'd3, v); chk("R1 cnt", v, 16'h0000);
    chk("R1 bus_req/done", {30'd0, bus_req, done}, 32'd0);

    // Receive channel: source register 0xF4 fixed, destination memory incrementing
    wr(2'd0, 16'h0068);
    wr(2'd1, 16'hABF4);
    wr(2'd2, 16'h0010);
    wr(2'd3, 16'd3);
    t0 = txns;
    pulse(); pulse();                       // R2: before GO, must be discarded
    wr(2'd0, 16'h0069);
    idle(20);
    rd(2'd3, v); chk("R2 count untouched", v, 16'd3);
    chk("R2 no bus traffic", txns - t0, 0);

    for (int i = 0; i < 2; i++) begin push(1'b0, 16'h0010 + 16'(i), exp_rx); exp_rx++; end
    pulse(); pulse();                       // R3: second request pends
    idle(30);
    chk("R3 two bytes moved", exp_q.size(), 0);
    chk("R3 two txn pairs", txns - t0, 4);
    rd(2'd3, v); chk("R9 live count", v, 16'd1);
    rd(2'd2, v); chk("R7 dst advanced", v, 16'h0012);
    rd(2'd1, v); chk("R7 src fixed", v, 16'hABF4);

    push(1'b0, 16'h0012, exp_rx); exp_rx++;
    pulse();
    wait_done("R10 done after last byte");
    chk("R3 last byte", exp_q.size(), 0);
    rd(2'd0, v); chk("R10 GO cleared Done set", v[1:0], 2'b10);
    t0 = txns;
    pulse(); pulse(); pulse();
    idle(20);
    chk("R10 requests ignored", txns - t0, 0);
    rd(2'd3, v); chk("R10 count stays zero", v, 16'd0);

    // Transmit channel: memory source incrementing, register 0x85 fixed (high byte ignored)
    wr(2'd1, 16'h0040);
    wr(2'd2, 16'h1285);
    wr(2'd3, 16'd4);
    for (int i = 0; i < 4; i++) push(1'b1, 16'h0085, pat(16'h0040 + 16'(i)));
    wr(2'd0, 16'h0099);
    pulse(); pulse(); pulse(); pulse();
    wait_done("R8 transmit run done");
    chk("R8 all bytes to register 0x85", exp_q.size(), 0);
    rd(2'd1, v); chk("R7 src advanced", v, 16'h0044);
    rd(2'd2, v); chk("R7 dst fixed", v, 16'h1285);

    // R5: free-running memory to memory
    wr(2'd1, 16'h0180);
    wr(2'd2, 16'h01C0);
    wr(2'd3, 16'd5);
    for (int i = 0; i < 5; i++) push(1'b0, 16'h01C0 + 16'(i), pat(16'h0180 + 16'(i)));
    wr(2'd0, 16'h0055);
    wait_done("R5 free run done");
    chk("R5 all bytes moved", exp_q.size(), 0);

    // R4: burst on a single request
    wr(2'd1, 16'h0020);
    wr(2'd2, 16'h0060);
    wr(2'd3, 16'd3);
    wr(2'd0, 16'h0051);
    t0 = txns;
    idle(15);
    chk("R4 waits for request", txns - t0, 0);
    for (int i = 0; i < 3; i++) push(1'b0, 16'h0060 + 16'(i), pat(16'h0020 + 16'(i)));
    pulse();
    wait_done("R4 burst done");
    chk("R4 whole count moved", exp_q.size(), 0);

    // R10: GO with a zero count
    wr(2'd3, 16'd0);
    t0 = txns;
    wr(2'd0, 16'h0055);
    idle(5);
    chk("R10 zero count done", {31'd0, done}, 32'd1);
    chk("R10 zero count no bus", txns - t0, 0);

    // R11: restart clears Done
    wr(2'd1, 16'h0090);
    wr(2'd2, 16'h00D0);
    wr(2'd3, 16'd2);
    for (int i = 0; i < 2; i++) push(1'b0, 16'h00D0 + 16'(i), pat(16'h0090 + 16'(i)));
    wr(2'd0, 16'h0055);
    chk("R11 Done cleared", {31'd0, done}, 32'd0);
    wait_done("R11 restart done");
    chk("R11 restart bytes", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule